// File: doc/BRIEF.md
# MD5 Streaming Message Padder

This block sits in front of an MD5 round engine. It accepts a message as a stream of bytes of any length and delivers the padded message as 512-bit chunks. Each chunk goes out as sixteen 32-bit words through a write strobe, a 4-bit word address and a data word, so the engine can fill its 16-word message memory directly.

Message bytes are packed four to a word, with the earliest byte in the least significant lane. When the last byte has been taken, the block appends the 0x80 marker byte and then zero bytes. It closes the message with the 64-bit bit length, split into a low word and a high word. If the marker lands too late in a chunk for the length to fit, the block zero-fills that chunk and emits one more chunk that carries only zeros and the length.

After every sixteenth word the block raises `chunkReady` and holds off both input and writes until `chunkAck` arrives. This gives the engine time to process the chunk. A message with no bytes is ended by a last beat flagged as empty.

Top module: `md5_pad_stream`

## Requirements
- R1: Message bytes are packed little-endian. The first byte of each group of four goes in `wrData[7:0]` and the fourth in `wrData[31:24]`. Within a chunk, words are written once each with `wrEn` high, at addresses 0 to 15 in ascending order.
- R2: The byte directly after the final message byte is 0x80, placed in the next free byte lane.
- R3: Every byte between the marker and the length field is zero.
- R4: Word 14 of the final chunk holds bits 31:0 of the message length in bits, and word 15 holds bits 63:32. The length in bits is 8 times the number of message bytes, taken modulo 2^64.
- R5: If the marker lands in chunk byte 56 or later, the rest of that chunk is zero. One more chunk follows, with zeros in words 0 to 13 and the length in words 14 and 15. A message of n bytes therefore yields floor((n+8)/64)+1 chunks.
- R6: If the message length is a nonzero multiple of 64 bytes, an extra chunk follows. Its word 0 is 0x00000080, words 1 to 13 are zero, and words 14 and 15 hold the length.
- R7: A beat accepted with `inLast=1` and `inEmpty=1` carries no byte. A message made of that beat alone gives one chunk: word 0 is 0x00000080 and all other words are 0.
- R8: `chunkReady` rises one cycle after the sixteenth write of a chunk. While it is high, `inReady` and `wrEn` stay low and `chunkReady` stays high until `chunkAck` is sampled high. The cycle after that edge, `chunkReady` is low.
- R9: A synchronous reset leaves `inReady=1`, `chunkReady=0` and `wrEn=0`. It discards any partial message, so the next message is padded as if nothing came before it.
- R10: After the final chunk of a message is acknowledged, the next message starts at word 0 with a length count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input beat present |
| inData | input | 8 | Message byte |
| inLast | input | 1 | Beat ends the message |
| inEmpty | input | 1 | With inLast: beat carries no byte |
| inReady | output | 1 | Beat is accepted on an edge where inValid and inReady are both high |
| wrEn | output | 1 | Word write strobe to the message memory |
| wrAddr | output | 4 | Word address within the chunk |
| wrData | output | 32 | Word data |
| chunkReady | output | 1 | A complete chunk has been written |
| chunkAck | input | 1 | Chunk consumed; output may continue |

## Verification
The word that completes four bytes appears on `wrEn`/`wrData` one cycle after the edge that accepts its fourth byte. Padding and length words follow at one per cycle. `chunkReady` rises one cycle after the sixteenth write, and it falls one cycle after the edge that samples `chunkAck`. The bench samples all outputs on the falling clock edge. It collects writes by address and compares a whole chunk the first time `chunkReady` is seen high, so random input gaps and acknowledge delays cannot shift a comparison. The one-cycle lag of `chunkReady` behind the acknowledge edge is checked in the cycle it is due.

// File: rtl/md5_pad_pkg.sv
package md5_pad_pkg;
  parameter int BYTE_W      = 8;
  parameter int WORD_W      = 32;
  parameter int CHUNK_WORDS = 16;
  parameter int LEN_W       = 64;

  localparam int ADDR_W     = $clog2(CHUNK_WORDS);
  localparam int LANES      = WORD_W / BYTE_W;
  localparam int LANE_W     = $clog2(LANES);
  localparam int LEN_LO_IDX = CHUNK_WORDS - 2;
  localparam logic [BYTE_W-1:0] MARKER = BYTE_W'(8'h80);

  typedef struct packed {
    logic takeByte;
    logic fillWord;
    logic withMarker;
    logic lenLo;
    logic lenHi;
    logic clearMsg;
  } padCtl_t;

  typedef enum logic [2:0] {
    ST_DATA,
    ST_FILL,
    ST_LENLO,
    ST_LENHI,
    ST_WAIT
  } padState_t;

  typedef enum logic [1:0] {
    RES_DATA,
    RES_FILL,
    RES_NEW
  } resume_t;
endpackage

// File: rtl/md5_pad_datapath.sv
module md5_pad_datapath
  import md5_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  padCtl_t           ctl,
  input  logic [BYTE_W-1:0] inData,
  output logic [LANE_W-1:0] byteIdx,
  output logic [ADDR_W-1:0] wordIdx,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData
);
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] packWord;
  logic [WORD_W-1:0] markWord;
  logic [LEN_W-1:0]  bitCount;
  logic              laneLast;

  assign laneLast = (byteIdx == LANE_W'(LANES - 1));

  // Lane muxes: incoming byte or marker goes to the current lane.
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign packWord[gi*BYTE_W +: BYTE_W] =
      (byteIdx == LANE_W'(gi)) ? inData : wordReg[gi*BYTE_W +: BYTE_W];
    assign markWord[gi*BYTE_W +: BYTE_W] =
      (byteIdx == LANE_W'(gi)) ? MARKER : wordReg[gi*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordReg  <= '0;
      byteIdx  <= '0;
      wordIdx  <= '0;
      bitCount <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrEn <= 1'b0;
      if (ctl.clearMsg) begin
        wordReg  <= '0;
        byteIdx  <= '0;
        wordIdx  <= '0;
        bitCount <= '0;
      end else if (ctl.takeByte) begin
        bitCount <= bitCount + LEN_W'(BYTE_W);
        byteIdx  <= byteIdx + 1'b1;
        if (laneLast) begin
          wrEn    <= 1'b1;
          wrAddr  <= wordIdx;
          wrData  <= packWord;
          wordIdx <= wordIdx + 1'b1;
          wordReg <= '0;
        end else begin
          wordReg <= packWord;
        end
      end else if (ctl.fillWord) begin
        wrEn    <= 1'b1;
        wrAddr  <= wordIdx;
        wrData  <= ctl.withMarker ? markWord : '0;
        wordIdx <= wordIdx + 1'b1;
        byteIdx <= '0;
        wordReg <= '0;
      end else if (ctl.lenLo || ctl.lenHi) begin
        wrEn    <= 1'b1;
        wrAddr  <= wordIdx;
        wrData  <= ctl.lenLo ? bitCount[WORD_W-1:0] : bitCount[LEN_W-1:WORD_W];
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  // R1: back-to-back writes walk the chunk addresses upward by one
  a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wrEn && $past(wrEn)) |-> (wrAddr == $past(wrAddr) + 1'b1));
endmodule

// File: rtl/md5_pad_control.sv
module md5_pad_control
  import md5_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              inEmpty,
  input  logic              chunkAck,
  input  logic              wrEn,
  input  logic [LANE_W-1:0] byteIdx,
  input  logic [ADDR_W-1:0] wordIdx,
  output logic              inReady,
  output logic              chunkReady,
  output padCtl_t           ctl
);
  padState_t state;
  resume_t   resume;
  logic      markerPending;
  logic      chunkFull;
  logic      ackTaken;

  always_comb begin
    ctl        = '0;
    inReady    = (state == ST_DATA);
    chunkReady = (state == ST_WAIT) && !wrEn;
    ackTaken   = chunkReady && chunkAck;
    unique case (state)
      ST_DATA:  ctl.takeByte = inValid && !(inLast && inEmpty);
      ST_FILL: begin
        ctl.fillWord   = 1'b1;
        ctl.withMarker = markerPending;
      end
      ST_LENLO: ctl.lenLo = 1'b1;
      ST_LENHI: ctl.lenHi = 1'b1;
      ST_WAIT:  ctl.clearMsg = ackTaken && (resume == RES_NEW);
      default:  ;
    endcase
    chunkFull = ctl.takeByte && (byteIdx == LANE_W'(LANES - 1)) &&
                (wordIdx == ADDR_W'(CHUNK_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_DATA;
      resume        <= RES_DATA;
      markerPending <= 1'b0;
    end else begin
      unique case (state)
        ST_DATA: begin
          if (inValid) begin
            if (inLast) begin
              markerPending <= 1'b1;
              if (chunkFull) begin
                state  <= ST_WAIT;
                resume <= RES_FILL;
              end else begin
                state <= ST_FILL;
              end
            end else if (chunkFull) begin
              state  <= ST_WAIT;
              resume <= RES_DATA;
            end
          end
        end
        ST_FILL: begin
          markerPending <= 1'b0;
          if (wordIdx == ADDR_W'(LEN_LO_IDX - 1)) begin
            state <= ST_LENLO;
          end else if (wordIdx == ADDR_W'(CHUNK_WORDS - 1)) begin
            state  <= ST_WAIT;
            resume <= RES_FILL;
          end
        end
        ST_LENLO: state <= ST_LENHI;
        ST_LENHI: begin
          state  <= ST_WAIT;
          resume <= RES_NEW;
        end
        ST_WAIT: begin
          if (ackTaken) begin
            state <= (resume == RES_FILL) ? ST_FILL : ST_DATA;
          end
        end
        default: state <= ST_DATA;
      endcase
    end
  end

  // R8: a raised chunkReady is held until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (chunkReady && !chunkAck) |=> chunkReady);

  // R8: waiting only ever happens on a chunk boundary
  a_r8_wait_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (wordIdx == '0));

  // R4: the low length word is written at word 14
  a_r4_len_slot: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LENLO) |-> (wordIdx == ADDR_W'(LEN_LO_IDX)));

  // R3: after a padding word the byte lane is back at zero
  a_r3_fill_lane_clear: assert property (@(posedge clk) disable iff (rst)
    $past(state == ST_FILL) |-> (byteIdx == '0));
endmodule

// File: rtl/md5_pad_stream.sv
module md5_pad_stream
  import md5_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  logic              inEmpty,
  output logic              inReady,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              chunkReady,
  input  logic              chunkAck
);
  padCtl_t           ctl;
  logic [LANE_W-1:0] byteIdx;
  logic [ADDR_W-1:0] wordIdx;

  md5_pad_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inLast     (inLast),
    .inEmpty    (inEmpty),
    .chunkAck   (chunkAck),
    .wrEn       (wrEn),
    .byteIdx    (byteIdx),
    .wordIdx    (wordIdx),
    .inReady    (inReady),
    .chunkReady (chunkReady),
    .ctl        (ctl)
  );

  md5_pad_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  (inData),
    .byteIdx (byteIdx),
    .wordIdx (wordIdx),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );
endmodule

// File: tb/md5_pad_stream_test.sv
module md5_pad_stream_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inEmpty = 1'b0;
  logic        inReady;
  logic        wrEn;
  logic [3:0]  wrAddr;
  logic [31:0] wrData;
  logic        chunkReady;
  logic        chunkAck = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  msg [0:255];
  logic [31:0] cbuf [0:15];

  always #4 clk = ~clk;

  md5_pad_stream uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inEmpty(inEmpty), .inReady(inReady), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .chunkReady(chunkReady), .chunkAck(chunkAck)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] padByte(input int len, input int p);
    int total = ((len + 8) / 64 + 1) * 64;
    logic [63:0] bits = 64'(len) * 64'd8;
    if (p < len) return msg[p];
    if (p == len) return 8'h80;
    if (p >= total - 8) return 8'(bits >> (8 * (p - (total - 8))));
    return 8'h00;
  endfunction

  function automatic logic [31:0] expWord(input int len, input int ci, input int w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = padByte(len, 64*ci + 4*w + k);
    return r;
  endfunction

  function automatic string wordTag(input int len, input int ci, input int w,
                                    input bit lastChunk, input string caseTag,
                                    input string lenTag);
    int base = 64*ci + 4*w;
    if (lastChunk && w >= 14) return lenTag;
    if (base + 3 < len) return "R1";
    if (base <= len && len <= base + 3) return (caseTag != "") ? caseTag : "R2";
    return (caseTag != "") ? caseTag : "R3";
  endfunction

  task automatic fillMsg(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
  endtask

  task automatic runMessage(input int len, input int gap, input string caseTag,
                            input string lenTag);
    int  nCh = (len + 8) / 64 + 1;
    int  beats = (len == 0) ? 1 : len;
    int  ptr = 0;
    int  ci = 0;
    int  wcount = 0;
    int  delay = 0;
    bit  acc = 1'b0;
    bit  waiting = 1'b0;
    bit  doneRun = 1'b0;
    for (int w = 0; w < 16; w++) cbuf[w] = 32'hDEAD_BEEF;
    while (!doneRun) begin
      @(negedge clk);
      if (chunkAck) begin
        chunkAck = 1'b0;
        check(!chunkReady, "R8", 64'(chunkReady), 64'd0);
        ci++;
        wcount = 0;
        waiting = 1'b0;
        if (ci == nCh) doneRun = 1'b1;
      end
      if (acc) ptr++;
      if (wrEn) begin
        cbuf[wrAddr] = wrData;
        wcount++;
      end
      if (chunkReady && !doneRun) begin
        if (!waiting) begin
          waiting = 1'b1;
          delay = int'($urandom % 4);
          check(wcount == 16, "R8", 64'(wcount), 64'd16);
          check(!inReady, "R8", 64'(inReady), 64'd0);
          for (int w = 0; w < 16; w++) begin
            logic [31:0] e = expWord(len, ci, w);
            check(cbuf[w] === e, wordTag(len, ci, w, ci == nCh - 1, caseTag, lenTag),
                  64'(cbuf[w]), 64'(e));
            cbuf[w] = 32'hDEAD_BEEF;
          end
        end
        if (delay == 0) chunkAck = 1'b1;
        else delay--;
      end else if (waiting && !doneRun) begin
        check(1'b0, "R8", 64'(chunkReady), 64'd1);
      end
      if (!doneRun && ptr < beats && int'($urandom % 100) >= gap) begin
        inValid = 1'b1;
        inData  = (len == 0) ? 8'h00 : msg[ptr];
        inLast  = (ptr == beats - 1);
        inEmpty = (len == 0);
      end else begin
        inValid = 1'b0;
        inLast  = 1'b0;
        inEmpty = 1'b0;
      end
      acc = inValid && inReady;
    end
    check(ci == nCh, "R5", 64'(ci), 64'(nCh));
    inValid = 1'b0;
    inLast  = 1'b0;
    inEmpty = 1'b0;
  endtask

  task automatic applyReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R9", 64'(inReady), 64'd1);
    check(chunkReady == 1'b0, "R9", 64'(chunkReady), 64'd0);
    check(wrEn == 1'b0, "R9", 64'(wrEn), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    applyReset();

    // R7: empty message
    runMessage(0, 0, "R7", "R7");
    // single-chunk cases, including the largest that fits (55 bytes)
    fillMsg(1);   runMessage(1, 30, "", "R10");
    fillMsg(3);   runMessage(3, 0, "", "R4");
    fillMsg(4);   runMessage(4, 50, "", "R4");
    fillMsg(55);  runMessage(55, 20, "", "R4");
    // R5: marker at byte 56 and later spills into an extra chunk
    fillMsg(56);  runMessage(56, 10, "R5", "R5");
    fillMsg(60);  runMessage(60, 0, "R5", "R5");
    fillMsg(63);  runMessage(63, 40, "R5", "R5");
    // R6: exact multiples of 64 bytes
    fillMsg(64);  runMessage(64, 25, "R6", "R6");
    fillMsg(128); runMessage(128, 0, "R6", "R6");
    fillMsg(119); runMessage(119, 15, "R5", "R4");

    // R9: reset in the middle of a message discards it
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = 8'($urandom);
      inLast  = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b0;
    applyReset();
    fillMsg(5);   runMessage(5, 0, "", "R9");

    // random lengths, back to back (R10)
    for (int r = 0; r < 8; r++) begin
      int len = int'($urandom % 170);
      fillMsg(len);
      runMessage(len, int'($urandom % 60), "", "R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule